// File: doc/BRIEF.md
# Descriptor-Chaining DMA Engine

This block moves blocks of 32-bit words between a local word-addressed RAM and a 64-bit host address space. It follows a list of transfer descriptors kept in host memory. Software sets up a small header register file: global flags, and the 64-bit base of a descriptor table. It then starts the engine by writing the index of the last descriptor to process. The engine reads the descriptors one after another. For each descriptor it copies the requested number of words. When enabled, it then records the index of the finished descriptor in a workspace word at the top of the table, so software can poll host memory to follow progress. It can also emit a one-cycle message-interrupt request per finished descriptor.

The host side is a single request port with one request in flight. A request is held until `hm_ready` accepts it. A read is answered by `hm_rvalid` with `hm_rdata` one or more cycles after acceptance. The local side is a RAM port with a read latency of one cycle. The transfer direction is fixed for each instance by the `DIR` parameter: 0 means host to local, 1 means local to host.

Header layout, each register written as one 32-bit access on `reg_addr`:
- Offset 0 holds the flags in bits 31:16. Bit 18 enables the completion write-back and bit 17 enables the interrupt request.
- Offsets 1 and 2 hold the upper and lower halves of the table base.
- Offset 3 is the start register, which takes the last index in bits 15:0.

The table is laid out as follows:
- Bytes 0x00–0x0B are a reserved workspace.
- Byte 0x0C is the completion word.
- Descriptor k starts at byte 0x10 + 16·k. It holds four words in this order:
  - flags in bits 31:16 (same bit meanings as the header) and length in words in bits 15:0;
  - the local word address;
  - the upper host address;
  - the lower host byte address.

Top module: `desc_chain_dma`

## Requirements
- R1: A write to offset 3 while `busy` is low, with bits 15:0 below MAX_DESC (255), raises `busy` on the next cycle. `busy` stays high until the last descriptor is finished. While `busy` is low, neither `hm_req` nor `lm_en` is asserted.
- R2: A write to offset 3 while `busy` is high, or with bits 15:0 of 255 or more, is ignored: the run in progress keeps its original last index, and an idle engine stays idle.
- R3: With last index L, descriptors 0 through L are processed in ascending order. Each descriptor is read from table base + 0x10 + 16·k in the word order given above.
- R4: With DIR=0, word i of a descriptor is read from host byte address host_base + 4·i and written to local word ep + i, for i below the length. Local words beyond ep + length − 1 are left unchanged, and a length of 0 moves nothing.
- R5: With DIR=1, local word ep + i is written to host byte address host_base + 4·i, for i below the length. Host words beyond the last one are left unchanged.
- R6: If bit 18 is set in the header flags or in the flags of descriptor k, then after all data words of descriptor k have moved, the engine writes the value k (zero-extended to 32 bits) to table base + 0x0C. With the bit clear in both places, the completion word is not written.
- R7: If bit 17 is set in the header flags or in the flags of descriptor k, `msi` pulses for exactly one cycle after descriptor k finishes. It never pulses while `busy` is low.
- R8: Writing 0x0000FFFF to offset 0 returns the engine to idle on the next cycle. The next start write then runs normally.
- R9: An `hm_req` that is not accepted stays asserted in the next cycle with unchanged address, write flag and write data.
- R10: Every host access carries the programmed upper address half: the table's upper half for descriptor and completion accesses, and the descriptor's upper half for data accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Header register write strobe |
| reg_addr | input | 2 | Header word offset |
| reg_wdata | input | 32 | Header write data |
| hm_req | output | 1 | Host request valid |
| hm_we | output | 1 | Host request is a write |
| hm_addr | output | 64 | Host byte address |
| hm_wdata | output | 32 | Host write data (little-endian word) |
| hm_ready | input | 1 | Host accepts the request this cycle |
| hm_rvalid | input | 1 | Host read data valid |
| hm_rdata | input | 32 | Host read data |
| lm_en | output | 1 | Local RAM access enable |
| lm_we | output | 1 | Local RAM write |
| lm_addr | output | LAW | Local RAM word address |
| lm_wdata | output | 32 | Local RAM write data |
| lm_rdata | input | 32 | Local RAM read data, one cycle after a read |
| busy | output | 1 | Chain in progress |
| msi | output | 1 | One-cycle message-interrupt request |

## Verification
The bench builds two instances: one with DIR=0 and one with DIR=1, both with an 8-bit local address and the default limit of 255 descriptors. In front of each is a host model whose acceptance stalls are driven by an LFSR. Every single-descriptor length from 0 to 7 is swept in both directions, so the zero-length path and the stalled-request hold condition occur many times. Multi-descriptor chains then mix global and per-descriptor flags, and the bench predicts completion order, interrupt counts and write-back progress by arithmetic. Ignored starts, an out-of-range last index and a soft reset in mid-chain are also exercised.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    localparam logic [31:0] SOFT_RESET_WORD = 32'h0000_FFFF;
    localparam int          FLG_WB          = 2;   // bit 18 of a 32-bit word
    localparam int          FLG_MSI         = 1;   // bit 17 of a 32-bit word
    localparam logic [63:0] WS_DONE_OFS     = 64'h0C;
    localparam logic [63:0] DESC_BASE_OFS   = 64'h10;

    typedef struct packed {
        logic wb;
        logic msi;
    } flags_t;

    typedef struct packed {
        flags_t      g;
        logic [63:0] tbl;
    } hdr_t;

    typedef struct packed {
        flags_t      f;
        logic [15:0] len;
    } desc_st_t;

    typedef enum logic [3:0] {
        S_IDLE, S_DREQ, S_DWAIT, S_LRD, S_LCAP, S_XREQ, S_XWAIT, S_WB, S_NEXT
    } st_e;

    function automatic logic [63:0] desc_word_addr(logic [63:0] base, logic [15:0] idx,
                                                   logic [1:0] w);
        return base + DESC_BASE_OFS + {44'b0, idx, 4'b0} + {60'b0, w, 2'b0};
    endfunction

    function automatic flags_t flags_of(logic [31:0] word);
        flags_t f;
        f.wb  = word[16 + FLG_WB];
        f.msi = word[16 + FLG_MSI];
        return f;
    endfunction

endpackage

// File: rtl/dma_hdr_regs.sv
module dma_hdr_regs
    import dma_chain_pkg::*;
#(
    parameter int MAX_DESC = 255
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        busy,
    output hdr_t        hdr,
    output logic        start,
    output logic        soft_rst
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hdr <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                2'd0:    hdr.g          <= flags_of(reg_wdata);
                2'd1:    hdr.tbl[63:32] <= reg_wdata;
                2'd2:    hdr.tbl[31:0]  <= reg_wdata;
                default: ;
            endcase
        end
    end

    assign soft_rst = reg_wr && (reg_addr == 2'd0) && (reg_wdata == SOFT_RESET_WORD);
    assign start    = reg_wr && (reg_addr == 2'd3) && !busy &&
                      (reg_wdata[15:0] < 16'(MAX_DESC));
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dma_chain_pkg::*;
#(
    parameter bit DIR = 1'b0,
    parameter int LAW = 12,
    parameter int IW  = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           soft_rst,
    input  logic           start,
    input  logic [IW-1:0]  last_in,
    input  hdr_t           hdr,
    output logic           hm_req,
    output logic           hm_we,
    output logic [63:0]    hm_addr,
    output logic [31:0]    hm_wdata,
    input  logic           hm_ready,
    input  logic           hm_rvalid,
    input  logic [31:0]    hm_rdata,
    output logic           lm_en,
    output logic           lm_we,
    output logic [LAW-1:0] lm_addr,
    output logic [31:0]    lm_wdata,
    input  logic [31:0]    lm_rdata,
    output logic           busy,
    output logic           msi
);
    st_e            st;
    logic [IW-1:0]  idx, last;
    logic [1:0]     wsel;
    desc_st_t       dsc;
    logic [15:0]    cnt;
    logic [63:0]    hptr;
    logic [LAW-1:0] lptr;
    logic [31:0]    dbuf;

    wire  last_word = (cnt + 16'd1 == dsc.len);
    st_e  done_st;
    assign done_st = (hdr.g.wb | dsc.f.wb) ? S_WB : S_NEXT;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            st <= S_IDLE; idx <= '0; last <= '0; wsel <= '0; dsc <= '0;
            cnt <= '0; hptr <= '0; lptr <= '0; dbuf <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    idx <= '0; last <= last_in; wsel <= '0; st <= S_DREQ;
                end
                S_DREQ: if (hm_ready) st <= S_DWAIT;
                S_DWAIT: if (hm_rvalid) begin
                    unique case (wsel)
                        2'd0: begin dsc.f <= flags_of(hm_rdata); dsc.len <= hm_rdata[15:0]; end
                        2'd1: lptr <= hm_rdata[LAW-1:0];
                        2'd2: hptr[63:32] <= hm_rdata;
                        default: hptr[31:0] <= hm_rdata;
                    endcase
                    wsel <= wsel + 2'd1;
                    if (wsel == 2'd3) begin
                        cnt <= '0;
                        if (dsc.len == 16'd0) st <= done_st;
                        else                  st <= DIR ? S_LRD : S_XREQ;
                    end else begin
                        st <= S_DREQ;
                    end
                end
                S_LRD:  st <= S_LCAP;
                S_LCAP: begin dbuf <= lm_rdata; st <= S_XREQ; end
                S_XREQ: if (hm_ready) begin
                    if (DIR) begin
                        hptr <= hptr + 64'd4; lptr <= lptr + 1'b1; cnt <= cnt + 16'd1;
                        st   <= last_word ? done_st : S_LRD;
                    end else begin
                        st <= S_XWAIT;
                    end
                end
                S_XWAIT: if (hm_rvalid) begin
                    hptr <= hptr + 64'd4; lptr <= lptr + 1'b1; cnt <= cnt + 16'd1;
                    st   <= last_word ? done_st : S_XREQ;
                end
                S_WB: if (hm_ready) st <= S_NEXT;
                S_NEXT: begin
                    if (idx == last) begin
                        st <= S_IDLE;
                    end else begin
                        idx <= idx + 1'b1; wsel <= '0; st <= S_DREQ;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        hm_req   = 1'b0;
        hm_we    = 1'b0;
        hm_addr  = hptr;
        hm_wdata = dbuf;
        lm_en    = 1'b0;
        lm_we    = 1'b0;
        lm_addr  = lptr;
        lm_wdata = hm_rdata;
        unique case (st)
            S_DREQ: begin
                hm_req  = 1'b1;
                hm_addr = desc_word_addr(hdr.tbl, 16'(idx), wsel);
            end
            S_XREQ: begin
                hm_req = 1'b1;
                hm_we  = DIR;
            end
            S_XWAIT: begin
                lm_en = hm_rvalid;
                lm_we = 1'b1;
            end
            S_LRD: lm_en = 1'b1;
            S_WB: begin
                hm_req   = 1'b1;
                hm_we    = 1'b1;
                hm_addr  = hdr.tbl + WS_DONE_OFS;
                hm_wdata = {{(32-IW){1'b0}}, idx};
            end
            default: ;
        endcase
    end

    assign busy = (st != S_IDLE);
    assign msi  = (st == S_NEXT) && (hdr.g.msi | dsc.f.msi);
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
    import dma_chain_pkg::*;
#(
    parameter bit DIR      = 1'b0,
    parameter int LAW      = 12,
    parameter int MAX_DESC = 255
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_wr,
    input  logic [1:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic           hm_req,
    output logic           hm_we,
    output logic [63:0]    hm_addr,
    output logic [31:0]    hm_wdata,
    input  logic           hm_ready,
    input  logic           hm_rvalid,
    input  logic [31:0]    hm_rdata,
    output logic           lm_en,
    output logic           lm_we,
    output logic [LAW-1:0] lm_addr,
    output logic [31:0]    lm_wdata,
    input  logic [31:0]    lm_rdata,
    output logic           busy,
    output logic           msi
);
    localparam int IW = $clog2(MAX_DESC + 1);

    hdr_t hdr;
    logic start, soft_rst;

    dma_hdr_regs #(.MAX_DESC(MAX_DESC)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .hdr(hdr), .start(start),
        .soft_rst(soft_rst)
    );

    dma_chain_engine #(.DIR(DIR), .LAW(LAW), .IW(IW)) u_eng (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .start(start),
        .last_in(reg_wdata[IW-1:0]), .hdr(hdr),
        .hm_req(hm_req), .hm_we(hm_we), .hm_addr(hm_addr), .hm_wdata(hm_wdata),
        .hm_ready(hm_ready), .hm_rvalid(hm_rvalid), .hm_rdata(hm_rdata),
        .lm_en(lm_en), .lm_we(lm_we), .lm_addr(lm_addr), .lm_wdata(lm_wdata),
        .lm_rdata(lm_rdata), .busy(busy), .msi(msi)
    );
endmodule

// File: rtl/desc_chain_dma_checker.sv
module desc_chain_dma_checker #(
    parameter bit DIR      = 1'b0,
    parameter int MAX_DESC = 255
) (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        hm_req,
    input logic        hm_we,
    input logic [63:0] hm_addr,
    input logic [31:0] hm_wdata,
    input logic        hm_ready,
    input logic        lm_en,
    input logic        lm_we,
    input logic        busy,
    input logic        msi
);
    wire soft_wr  = reg_wr && reg_addr == 2'd0 && reg_wdata == 32'h0000_FFFF;
    wire start_wr = reg_wr && reg_addr == 2'd3;

    assert_start_busy_R1: assert property (@(posedge clk) disable iff (rst)
        (start_wr && !busy && reg_wdata[15:0] < 16'(MAX_DESC)) |=> busy);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!hm_req && !lm_en));

    assert_bad_start_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (start_wr && !busy && reg_wdata[15:0] >= 16'(MAX_DESC)) |=> !busy);

    assert_local_write_dir_R5: assert property (@(posedge clk) disable iff (rst)
        (lm_en && lm_we) |-> (DIR == 1'b0));

    assert_msi_in_run_R7: assert property (@(posedge clk) disable iff (rst)
        msi |-> busy);

    assert_soft_reset_idle_R8: assert property (@(posedge clk) disable iff (rst)
        soft_wr |=> !busy);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (hm_req && !hm_ready && !soft_wr) |=>
            (hm_req && $stable(hm_addr) && $stable(hm_we) && $stable(hm_wdata)));
endmodule

bind desc_chain_dma desc_chain_dma_checker #(.DIR(DIR), .MAX_DESC(MAX_DESC)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .hm_req(hm_req), .hm_we(hm_we), .hm_addr(hm_addr), .hm_wdata(hm_wdata),
    .hm_ready(hm_ready), .lm_en(lm_en), .lm_we(lm_we), .busy(busy), .msi(msi)
);

// File: tb/desc_chain_dma_tb.sv
module dma_tb_mem (
    input  logic        clk,
    input  logic        rst,
    input  logic        hm_req,
    input  logic        hm_we,
    input  logic [63:0] hm_addr,
    input  logic [31:0] hm_wdata,
    output logic        hm_ready,
    output logic        hm_rvalid,
    output logic [31:0] hm_rdata,
    input  logic        lm_en,
    input  logic        lm_we,
    input  logic [7:0]  lm_addr,
    input  logic [31:0] lm_wdata,
    output logic [31:0] lm_rdata,
    input  logic        msi,
    input  logic        pl_en,
    input  logic        pl_local,
    input  logic [11:0] pl_idx,
    input  logic [31:0] pl_data,
    input  logic        clr,
    input  logic [1:0]  rd_kind,
    input  logic [11:0] rd_idx,
    output logic [31:0] rd_data,
    output int          log_n,
    output int          msi_n,
    output int          bad_hi
);
    logic [31:0] hmem [4096];
    logic [31:0] lram [256];
    logic [31:0] lval [16];
    logic [31:0] lcnt [16];
    int          xfer;
    logic [7:0]  lfsr;
    wire  [11:0] hidx = hm_addr[13:2];

    assign hm_ready = lfsr[0] | lfsr[2];

    always_comb begin
        case (rd_kind)
            2'd0:    rd_data = hmem[rd_idx];
            2'd1:    rd_data = lram[rd_idx[7:0]];
            2'd2:    rd_data = lval[rd_idx[3:0]];
            default: rd_data = lcnt[rd_idx[3:0]];
        endcase
    end

    always @(posedge clk) begin
        if (rst) begin
            lfsr <= 8'h5B; hm_rvalid <= 1'b0; hm_rdata <= '0; lm_rdata <= '0;
            log_n <= 0; msi_n <= 0; bad_hi <= 0; xfer <= 0;
        end else begin
            lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            hm_rvalid <= 1'b0;
            if (hm_req && hm_ready) begin
                if (hm_addr[63:32] != 32'd1 || hm_addr[31:14] != '0) bad_hi <= bad_hi + 1;
                if (hm_we) begin
                    hmem[hidx] <= hm_wdata;
                    if (hidx >= 12'd2048) xfer <= xfer + 1;
                    if (hidx == 12'd3 && log_n < 16) begin
                        lval[log_n[3:0]] <= hm_wdata;
                        lcnt[log_n[3:0]] <= 32'(xfer);
                        log_n <= log_n + 1;
                    end
                end else begin
                    hm_rvalid <= 1'b1;
                    hm_rdata  <= hmem[hidx];
                end
            end
            if (lm_en) begin
                if (lm_we) begin
                    lram[lm_addr] <= lm_wdata;
                    xfer <= xfer + 1;
                end else begin
                    lm_rdata <= lram[lm_addr];
                end
            end
            if (msi) msi_n <= msi_n + 1;
            if (pl_en) begin
                if (pl_local) lram[pl_idx[7:0]] <= pl_data;
                else          hmem[pl_idx]      <= pl_data;
            end
            if (clr) begin
                log_n <= 0; msi_n <= 0; xfer <= 0; bad_hi <= 0;
            end
        end
    end
endmodule

module desc_chain_dma_tb_top;
    localparam int LAW = 8;
    localparam logic [15:0] G_WB  = 16'h0004;
    localparam logic [15:0] G_MSI = 16'h0002;
    localparam logic [31:0] SENT  = 32'h5E5E_5E5E;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        reg_wr [2];
    logic [1:0]  reg_addr [2];
    logic [31:0] reg_wdata [2];
    logic        hm_req [2], hm_we [2], hm_ready [2], hm_rvalid [2];
    logic [63:0] hm_addr [2];
    logic [31:0] hm_wdata [2], hm_rdata [2];
    logic        lm_en [2], lm_we [2];
    logic [7:0]  lm_addr [2];
    logic [31:0] lm_wdata [2], lm_rdata [2];
    logic        busy [2], msi [2];
    logic        pl_en [2], pl_local [2], clr [2];
    logic [11:0] pl_idx [2], rd_idx [2];
    logic [31:0] pl_data [2], rd_data [2];
    logic [1:0]  rd_kind [2];
    int          log_n [2], msi_n [2], bad_hi [2];

    desc_chain_dma #(.DIR(1'b0), .LAW(LAW)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr[0]), .reg_addr(reg_addr[0]),
        .reg_wdata(reg_wdata[0]), .hm_req(hm_req[0]), .hm_we(hm_we[0]),
        .hm_addr(hm_addr[0]), .hm_wdata(hm_wdata[0]), .hm_ready(hm_ready[0]),
        .hm_rvalid(hm_rvalid[0]), .hm_rdata(hm_rdata[0]), .lm_en(lm_en[0]),
        .lm_we(lm_we[0]), .lm_addr(lm_addr[0]), .lm_wdata(lm_wdata[0]),
        .lm_rdata(lm_rdata[0]), .busy(busy[0]), .msi(msi[0])
    );

    desc_chain_dma #(.DIR(1'b1), .LAW(LAW)) dut_e2h_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr[1]), .reg_addr(reg_addr[1]),
        .reg_wdata(reg_wdata[1]), .hm_req(hm_req[1]), .hm_we(hm_we[1]),
        .hm_addr(hm_addr[1]), .hm_wdata(hm_wdata[1]), .hm_ready(hm_ready[1]),
        .hm_rvalid(hm_rvalid[1]), .hm_rdata(hm_rdata[1]), .lm_en(lm_en[1]),
        .lm_we(lm_we[1]), .lm_addr(lm_addr[1]), .lm_wdata(lm_wdata[1]),
        .lm_rdata(lm_rdata[1]), .busy(busy[1]), .msi(msi[1])
    );

    dma_tb_mem m0 (
        .clk(clk), .rst(rst), .hm_req(hm_req[0]), .hm_we(hm_we[0]), .hm_addr(hm_addr[0]),
        .hm_wdata(hm_wdata[0]), .hm_ready(hm_ready[0]), .hm_rvalid(hm_rvalid[0]),
        .hm_rdata(hm_rdata[0]), .lm_en(lm_en[0]), .lm_we(lm_we[0]), .lm_addr(lm_addr[0]),
        .lm_wdata(lm_wdata[0]), .lm_rdata(lm_rdata[0]), .msi(msi[0]), .pl_en(pl_en[0]),
        .pl_local(pl_local[0]), .pl_idx(pl_idx[0]), .pl_data(pl_data[0]), .clr(clr[0]),
        .rd_kind(rd_kind[0]), .rd_idx(rd_idx[0]), .rd_data(rd_data[0]),
        .log_n(log_n[0]), .msi_n(msi_n[0]), .bad_hi(bad_hi[0])
    );

    dma_tb_mem m1 (
        .clk(clk), .rst(rst), .hm_req(hm_req[1]), .hm_we(hm_we[1]), .hm_addr(hm_addr[1]),
        .hm_wdata(hm_wdata[1]), .hm_ready(hm_ready[1]), .hm_rvalid(hm_rvalid[1]),
        .hm_rdata(hm_rdata[1]), .lm_en(lm_en[1]), .lm_we(lm_we[1]), .lm_addr(lm_addr[1]),
        .lm_wdata(lm_wdata[1]), .lm_rdata(lm_rdata[1]), .msi(msi[1]), .pl_en(pl_en[1]),
        .pl_local(pl_local[1]), .pl_idx(pl_idx[1]), .pl_data(pl_data[1]), .clr(clr[1]),
        .rd_kind(rd_kind[1]), .rd_idx(rd_idx[1]), .rd_data(rd_data[1]),
        .log_n(log_n[1]), .msi_n(msi_n[1]), .bad_hi(bad_hi[1])
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int          d_len [8];
    int          d_ep  [8];
    int          d_ho  [8];
    logic [15:0] d_ctl [8];

    function automatic logic [31:0] hpat(int j);
        return ((32'(j) + 32'd1) * 32'h9E37_79B9) ^ 32'(j);
    endfunction

    function automatic logic [31:0] lpat(int a);
        return (32'(a) * 32'h0100_0193) ^ 32'h5A5A_5A5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int u, input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr[u] = 1'b1; reg_addr[u] = a; reg_wdata[u] = v;
        @(negedge clk);
        reg_wr[u] = 1'b0;
    endtask

    task automatic preload(input int u, input bit loc, input int idx, input logic [31:0] v);
        @(negedge clk);
        pl_en[u] = 1'b1; pl_local[u] = loc; pl_idx[u] = 12'(idx); pl_data[u] = v;
        @(negedge clk);
        pl_en[u] = 1'b0;
    endtask

    task automatic rd(input int u, input logic [1:0] kind, input int idx,
                      output logic [31:0] v);
        rd_kind[u] = kind; rd_idx[u] = 12'(idx);
        #1;
        v = rd_data[u];
    endtask

    task automatic pulse_clr(input int u);
        @(negedge clk); clr[u] = 1'b1;
        @(negedge clk); clr[u] = 1'b0;
    endtask

    task automatic wait_idle(input int u);
        int n;
        n = 0;
        while (busy[u] && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 5000, "R1 run completes", 32'(n), 32'd5000);
    endtask

    // Descriptors at host word 4+4k; data window at host word 2048 (byte 0x2000)
    task automatic setup(input int u, input int last, input logic [15:0] gctl);
        pulse_clr(u);
        for (int k = 0; k <= last; k++) begin
            preload(u, 1'b0, 4 + 4*k,     {d_ctl[k], 16'(d_len[k])});
            preload(u, 1'b0, 4 + 4*k + 1, 32'(d_ep[k]));
            preload(u, 1'b0, 4 + 4*k + 2, 32'd1);
            preload(u, 1'b0, 4 + 4*k + 3, 32'h2000 + 32'(4 * d_ho[k]));
            if (u == 0) preload(u, 1'b1, d_ep[k] + d_len[k], SENT);
            else        preload(u, 1'b0, 2048 + d_ho[k] + d_len[k], SENT);
        end
        preload(u, 1'b0, 3, 32'hFFFF_FFFF);
        wr_reg(u, 2'd0, {gctl, 16'(last + 1)});
        wr_reg(u, 2'd1, 32'd1);
        wr_reg(u, 2'd2, 32'd0);
    endtask

    task automatic go(input int u, input int last, input bit poke);
        wr_reg(u, 2'd3, 32'(last));
        chk(busy[u] == 1'b1, "R1 busy after start", 32'(busy[u]), 32'd1);
        if (poke) begin
            repeat (3) @(negedge clk);
            wr_reg(u, 2'd3, 32'd0);
            chk(busy[u] == 1'b1, "R2 start while busy keeps run", 32'(busy[u]), 32'd1);
        end
        wait_idle(u);
        chk(!hm_req[u] && !lm_en[u], "R1 quiet when idle",
            {30'd0, hm_req[u], lm_en[u]}, 32'd0);
    endtask

    task automatic verify(input int u, input int last, input logic [15:0] gctl);
        int cum, e, nm;
        logic [31:0] v;
        cum = 0; e = 0; nm = 0;
        for (int k = 0; k <= last; k++) begin
            for (int i = 0; i < d_len[k]; i++) begin
                if (u == 0) begin
                    rd(u, 2'd1, d_ep[k] + i, v);
                    chk(v == hpat(d_ho[k] + i), "R4 host-to-local word", v, hpat(d_ho[k] + i));
                end else begin
                    rd(u, 2'd0, 2048 + d_ho[k] + i, v);
                    chk(v == lpat(d_ep[k] + i), "R5 local-to-host word", v, lpat(d_ep[k] + i));
                end
            end
            if (u == 0) begin
                rd(u, 2'd1, d_ep[k] + d_len[k], v);
                chk(v == SENT, "R4 word past length untouched", v, SENT);
            end else begin
                rd(u, 2'd0, 2048 + d_ho[k] + d_len[k], v);
                chk(v == SENT, "R5 word past length untouched", v, SENT);
            end
            cum += d_len[k];
            if (gctl[2] || d_ctl[k][2]) begin
                rd(u, 2'd2, e, v);
                chk(v == 32'(k), "R3 R6 completion order", v, 32'(k));
                rd(u, 2'd3, e, v);
                chk(v == 32'(cum), "R6 completion after data", v, 32'(cum));
                e++;
            end
            if (gctl[1] || d_ctl[k][1]) nm++;
        end
        chk(log_n[u] == e, "R6 completion write count", 32'(log_n[u]), 32'(e));
        if (e == 0) begin
            rd(u, 2'd0, 3, v);
            chk(v == 32'hFFFF_FFFF, "R6 workspace untouched", v, 32'hFFFF_FFFF);
        end
        chk(msi_n[u] == nm, "R7 interrupt pulse count", 32'(msi_n[u]), 32'(nm));
        chk(bad_hi[u] == 0, "R10 upper address half", 32'(bad_hi[u]), 32'd0);
    endtask

    task automatic layout(input int n, input int len, input logic [15:0] ctl);
        for (int k = 0; k < n; k++) begin
            d_len[k] = len; d_ep[k] = 10 + 20*k; d_ho[k] = 24*k + 5; d_ctl[k] = ctl;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int u = 0; u < 2; u++) begin
            reg_wr[u] = 0; reg_addr[u] = 0; reg_wdata[u] = 0; pl_en[u] = 0;
            pl_local[u] = 0; pl_idx[u] = 0; pl_data[u] = 0; clr[u] = 0;
            rd_kind[u] = 0; rd_idx[u] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int u = 0; u < 2; u++) begin
            chk(!busy[u] && !hm_req[u] && !lm_en[u] && !msi[u], "R1 reset state",
                {28'd0, busy[u], hm_req[u], lm_en[u], msi[u]}, 32'd0);
        end

        // Sources: host data window for DIR=0, local RAM for DIR=1
        for (int j = 0; j < 256; j++) preload(0, 1'b0, 2048 + j, hpat(j));
        for (int a = 0; a < 256; a++) preload(1, 1'b1, a, lpat(a));

        // Sweep single-descriptor lengths 0..7 both directions (R3 R4 R5 R6)
        for (int u = 0; u < 2; u++) begin
            for (int len = 0; len < 8; len++) begin
                d_len[0] = len; d_ep[0] = 3 + 9*len; d_ho[0] = 11*len + 1; d_ctl[0] = 16'h0;
                setup(u, 0, G_WB);
                go(u, 0, 1'b0);
                verify(u, 0, G_WB);
            end
        end

        // Chains with mixed lengths and per-descriptor interrupt flags (R3 R7)
        for (int u = 0; u < 2; u++) begin
            layout(4, 3, 16'h0);
            d_len[1] = 0; d_len[2] = 5; d_len[3] = 2;
            d_ctl[1] = G_MSI; d_ctl[3] = G_MSI;
            setup(u, 3, G_WB);
            go(u, 3, 1'b0);
            verify(u, 3, G_WB);
        end

        // Per-descriptor write-back only, global interrupt (R6 R7)
        for (int u = 0; u < 2; u++) begin
            layout(4, 4, 16'h0);
            d_ctl[1] = G_WB; d_ctl[3] = G_WB;
            setup(u, 3, G_MSI);
            go(u, 3, 1'b0);
            verify(u, 3, G_MSI);
        end

        // No write-back anywhere (R6)
        layout(3, 2, 16'h0);
        setup(0, 2, 16'h0);
        go(0, 2, 1'b0);
        verify(0, 2, 16'h0);

        // Start write while busy is ignored (R2)
        for (int u = 0; u < 2; u++) begin
            layout(4, 7, 16'h0);
            setup(u, 3, G_WB);
            go(u, 3, 1'b1);
            verify(u, 3, G_WB);
        end

        // Out-of-range last index is ignored (R2)
        layout(1, 2, 16'h0);
        setup(0, 0, G_WB);
        wr_reg(0, 2'd3, 32'd255);
        chk(busy[0] == 1'b0, "R2 last index 255 ignored", 32'(busy[0]), 32'd0);
        repeat (20) @(negedge clk);
        chk(log_n[0] == 0, "R2 no activity after bad start", 32'(log_n[0]), 32'd0);
        rd(0, 2'd0, 3, v);
        chk(v == 32'hFFFF_FFFF, "R2 workspace untouched", v, 32'hFFFF_FFFF);

        // Soft reset in the middle of a chain, then a normal run (R8)
        for (int u = 0; u < 2; u++) begin
            layout(4, 7, 16'h0);
            setup(u, 3, G_WB);
            wr_reg(u, 2'd3, 32'd3);
            repeat (15) @(negedge clk);
            wr_reg(u, 2'd0, 32'h0000_FFFF);
            chk(busy[u] == 1'b0, "R8 soft reset idles", 32'(busy[u]), 32'd0);
            repeat (10) @(negedge clk);
            chk(busy[u] == 1'b0 && !hm_req[u], "R8 stays idle",
                {30'd0, busy[u], hm_req[u]}, 32'd0);
            layout(2, 3, 16'h0);
            d_ep[0] = 100; d_ep[1] = 130; d_ho[0] = 150; d_ho[1] = 170;
            setup(u, 1, G_WB | G_MSI);
            go(u, 1, 1'b0);
            verify(u, 1, G_WB | G_MSI);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule